// File: doc/BRIEF.md
# Weighted Burst-Stream FIR Filter

This block filters a serial unary stream. In that stream a value is the count of ones over any run of consecutive beats. A short 1-bit delay line holds the most recent input beats. Its taps drive a binary tree of carry-keeping one-bit adder cells. Each cell adds its two input bits and its own stored remainder bit. It passes on only the carry, so every level of the tree halves the stream value. The remainder goes into a flip-flop and is added back on the next beat. Nothing is truncated or rounded, and the stream needs no framing.

A tap's integer weight comes only from the tree level at which it enters: level k weighs 2^(k-1). A weight that is not a power of two uses one copy of the tap per set bit. A negative weight uses an inverted copy of the tap, which is valid under the offset-by-half encoding. A tree input with no tap is fed a constant stream that stands for zero. In offset mode that stream alternates 0,1,0,1. In unsigned mode it is all zeros. The wiring is a compile-time table that gives, for each adder node and each input port, one of four sources: a child node, the zero stream, a tap, or an inverted tap.

Input and output use valid-qualified beats. `in_valid` marks a burst clock pulse, and only those beats move the filter. `out_valid` marks the beat that carries the result. The block has no back-pressure: it takes every valid beat, and the consumer must take every output beat.

Top module: `burst_fir`

## Requirements
- R1: On every valid beat each adder cell obeys a + b + r = 2·carry + r', where r is its stored remainder before the beat and r' is the remainder after it. The carry is the only bit the cell passes on.
- R2: The default tree has four levels. Its slots are node 1 (level 4) with port A from child 2 and port B from tap 1, and node 2 (level 3) with port A from child 4 and port B from tap 3 inverted. Node 4 (level 2) takes both children, 8 and 9. Node 8 (level 1) takes tap 0 and the zero stream, and node 9 (level 1) takes tap 2 inverted and tap 1. Let x_i be tap i during a beat and z the zero-stream bit. Per valid beat the weighted input is x0 + 9·x1 + (1−x2) + 4·(1−x3) + z. Over all beats since reset, this total minus 16 times the count of output ones always lies in 0..16.
- R3: Tap 1 weighs 9, through levels 1 and 4 together. With the input held at all ones, any 64 consecutive valid beats after the delay line has filled produce 41 to 43 output ones.
- R4: Inverted taps give negative weights. With the input held at all zeros, any 64 consecutive valid beats after the delay line has filled produce 21 to 23 output ones.
- R5: In offset mode the zero stream reads 0 on the first valid beat after reset and toggles on every valid beat.
- R6: A cycle with `in_valid` low changes no state: the delay line, the remainders and the zero stream hold, `out_data` holds and `out_valid` is low on the next cycle.
- R7: Reset is synchronous and active high. It clears the delay line, every remainder and the zero-stream phase, and drives `out_valid` and `out_data` to 0.
- R8: `out_valid` is `in_valid` delayed by one clock. The `out_data` bit that comes with it is the root carry formed during that beat.
- R9: Tap i holds the input bit from i+1 valid beats earlier, so tap 0 is the previous valid input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks a burst beat; filter state advances only when high |
| in_data | input | 1 | Serial burst input bit |
| out_valid | output | 1 | High one clock after a valid input beat |
| out_data | output | 1 | Serial burst output bit |

## Verification
The hardest state to reach is the one where the stored remainders sit at or near their joint limit, so that the conservation bound is tight at both ends. Long runs of constant ones and constant zeros pin the tree into its steady remainder cycle. Segments of random data at very low and very high ones density, with random idle cycles between beats, then move the remainders toward both extremes. A reference in the bench tracks the weighted input total and the output count independently of the tree structure, and it checks the bound on every clock.

// File: rtl/burst_fir_pkg.sv
package burst_fir_pkg;
  // Source codes for an adder input port in the wiring table (>= 0 selects a tap).
  localparam int SRC_CHILD = -2;
  localparam int SRC_ZERO  = -1;
  localparam int SRC_NONE  = -3;
endpackage

// File: rtl/burst_tap_line.sv
module burst_tap_line #(
  parameter int NTAPS = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             din,
  output logic [NTAPS-1:0] taps
);
  logic [NTAPS-1:0] line_q;

  always_ff @(posedge clk) begin
    if (rst)     line_q <= '0;
    else if (en) line_q <= {line_q[NTAPS-2:0], din};
  end

  assign taps = line_q;

  // R9
  tap0_capture_chk: assert property (@(posedge clk) disable iff (rst)
    en |=> line_q[0] == $past(din));
  // R6
  line_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(line_q));
endmodule

// File: rtl/burst_zero_src.sv
module burst_zero_src #(
  parameter bit OFFSET_ZERO = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic zbit
);
  logic phase_q;

  always_ff @(posedge clk) begin
    if (rst)     phase_q <= 1'b0;
    else if (en) phase_q <= ~phase_q;
  end

  assign zbit = OFFSET_ZERO ? phase_q : 1'b0;

  if (OFFSET_ZERO) begin : g_chk
    // R5
    zero_toggle_chk: assert property (@(posedge clk) disable iff (rst)
      en |=> zbit != $past(zbit));
    // R6
    zero_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !en |=> $stable(zbit));
  end
endmodule

// File: rtl/burst_carry_cell.sv
module burst_carry_cell (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic a,
  input  logic b,
  output logic carry
);
  logic rem_q;

  assign carry = (a & b) | (a & rem_q) | (b & rem_q);

  always_ff @(posedge clk) begin
    if (rst)     rem_q <= 1'b0;
    else if (en) rem_q <= a ^ b ^ rem_q;
  end

  // R1
  cell_balance_chk: assert property (@(posedge clk) disable iff (rst)
    en |=> (int'(rem_q) + 2 * int'($past(carry))) ==
           (int'($past(a)) + int'($past(b)) + int'($past(rem_q))));
  // R6
  cell_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(rem_q));
endmodule

// File: rtl/burst_fir.sv
module burst_fir
  import burst_fir_pkg::*;
#(
  parameter int LEVELS      = 4,
  parameter int NTAPS       = 4,
  parameter bit OFFSET_ZERO = 1'b1,
  parameter int SRC_A [2**LEVELS] = '{SRC_NONE, SRC_CHILD, SRC_CHILD, SRC_NONE,
                                      SRC_CHILD, SRC_NONE, SRC_NONE, SRC_NONE,
                                      0, 2, SRC_NONE, SRC_NONE,
                                      SRC_NONE, SRC_NONE, SRC_NONE, SRC_NONE},
  parameter int SRC_B [2**LEVELS] = '{SRC_NONE, 1, 3, SRC_NONE,
                                      SRC_CHILD, SRC_NONE, SRC_NONE, SRC_NONE,
                                      SRC_ZERO, 1, SRC_NONE, SRC_NONE,
                                      SRC_NONE, SRC_NONE, SRC_NONE, SRC_NONE},
  parameter logic [2**LEVELS-1:0] NEG_A = 16'h0200,
  parameter logic [2**LEVELS-1:0] NEG_B = 16'h0004
) (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic in_data,
  output logic out_valid,
  output logic out_data
);
  localparam int NODES = 2**LEVELS;

  // A node exists when every ancestor port on its path selects a child.
  function automatic bit node_on(input int idx);
    int k;
    int src;
    bit on;
    on = 1'b1;
    k  = idx;
    for (int s = 0; s < LEVELS; s++) begin
      if (k > 1) begin
        src = (k % 2 == 1) ? SRC_B[k/2] : SRC_A[k/2];
        if (src != SRC_CHILD) on = 1'b0;
        k = k / 2;
      end
    end
    return on;
  endfunction

  logic [NTAPS-1:0] taps;
  logic             zbit;

  burst_tap_line #(.NTAPS(NTAPS)) u_line (
    .clk(clk), .rst(rst), .en(in_valid), .din(in_data), .taps(taps)
  );

  burst_zero_src #(.OFFSET_ZERO(OFFSET_ZERO)) u_zero (
    .clk(clk), .rst(rst), .en(in_valid), .zbit(zbit)
  );

  for (genvar j = 1; j < NODES; j++) begin : gen_node
    if (node_on(j)) begin : g_on
      logic a, b, carry;

      if (SRC_A[j] == SRC_CHILD) begin : g_a
        assign a = gen_node[2*j].g_on.carry;
      end else if (SRC_A[j] == SRC_ZERO) begin : g_a
        assign a = zbit;
      end else begin : g_a
        assign a = taps[SRC_A[j]] ^ NEG_A[j];
      end

      if (SRC_B[j] == SRC_CHILD) begin : g_b
        assign b = gen_node[2*j+1].g_on.carry;
      end else if (SRC_B[j] == SRC_ZERO) begin : g_b
        assign b = zbit;
      end else begin : g_b
        assign b = taps[SRC_B[j]] ^ NEG_B[j];
      end

      burst_carry_cell u_cell (
        .clk(clk), .rst(rst), .en(in_valid), .a(a), .b(b), .carry(carry)
      );
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_data <= gen_node[1].g_on.carry;
    end
  end

  // R7
  reset_out_chk: assert property (@(posedge clk)
    rst |=> !out_valid && !out_data);
  // R8
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid && $stable(out_data));
endmodule

// File: tb/burst_fir_bench.sv
`timescale 1ns/1ps
module burst_fir_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_data = 1'b0;
  logic out_valid, out_data;

  always #2.5 clk = ~clk;

  burst_fir u_burst_fir (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  int   n_vec = 0;
  int   n_bad = 0;
  bit   done  = 0;
  logic [3:0] hist = '0;   // hist[i] = input from i+1 valid beats ago (R9)
  logic zmod = 1'b0;       // zero stream model (R5)
  longint wsum = 0;        // weighted input total (R2)
  longint ones = 0;        // output ones count
  logic prev_out = 1'b0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int weight_in(input logic [3:0] h, input logic z);
    return int'(h[0]) + 9 * int'(h[1]) + (1 - int'(h[2])) + 4 * (1 - int'(h[3])) + int'(z);
  endfunction

  // Called at a falling edge: drive one cycle, then check at the next falling edge.
  task automatic beat(input logic v, input logic d);
    int contrib;
    in_valid = v;
    in_data  = d;
    contrib  = weight_in(hist, zmod);
    @(negedge clk);
    if (v) begin
      wsum += contrib;
      hist  = {hist[2:0], d};
      zmod  = ~zmod;
    end
    // R8
    chk(out_valid == v, "R8", out_valid, v);
    if (!v) begin
      // R6: idle cycle leaves the output bit unchanged
      chk(out_data == prev_out, "R6", out_data, prev_out);
    end
    if (out_valid) ones += out_data;
    prev_out = out_data;
    // R2: 0 <= wsum - 16*ones <= 16
    chk((wsum - 16 * ones) >= 0 && (wsum - 16 * ones) <= 16, "R2", wsum - 16 * ones, 8);
  endtask

  task automatic window(input logic d, input string req, input int lo, input int hi);
    longint start;
    for (int i = 0; i < 8; i++) beat(1'b1, d);
    start = ones;
    for (int i = 0; i < 64; i++) beat(1'b1, d);
    chk((ones - start) >= lo && (ones - start) <= hi, req, ones - start, lo);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R7: reset state
    chk(out_valid == 1'b0, "R7", out_valid, 0);
    chk(out_data == 1'b0, "R7", out_data, 0);
    rst = 1'b0;
    // R5: zero stream starts at 0, so the first beat with zero input yields 5/16
    beat(1'b1, 1'b0);
    chk(out_data == 1'b0, "R5", out_data, 0);
    // R3: tap 1 weight 9 via levels 1 and 4
    window(1'b1, "R3", 41, 43);
    // R4: inverted taps contribute negative weight
    window(1'b0, "R4", 21, 23);
    // R6: long idle stretch, state must be frozen
    for (int i = 0; i < 20; i++) beat(1'b0, i[0]);
    window(1'b1, "R3", 41, 43);
    // R9/R2: alternating data
    for (int i = 0; i < 200; i++) beat(1'b1, i[0]);
    // Random data at low, mid and high density with random idle gaps
    for (int seg = 0; seg < 6; seg++) begin
      for (int i = 0; i < 600; i++) begin
        int dens;
        dens = (seg % 3 == 0) ? 1 : ((seg % 3 == 1) ? 4 : 7);
        beat(($urandom % 4) != 0, ($urandom % 8) < dens);
      end
    end
    // R7: reset mid-stream clears everything
    in_valid = 1'b1;
    in_data  = 1'b1;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    in_valid = 1'b0;
    chk(out_valid == 1'b0, "R7", out_valid, 0);
    chk(out_data == 1'b0, "R7", out_data, 0);
    hist = '0; zmod = 1'b0; wsum = 0; ones = 0; prev_out = 1'b0;
    window(1'b0, "R4", 21, 23);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule